// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This block is the control heart of a small multi-cycle 32-bit integer processor. It holds the instruction register and a 4-bit micro-step counter, and it reads a control store addressed by nothing more than selected instruction bits placed next to the step count. Every cycle it presents one 32-bit control word, which the surrounding datapath decodes into register, ALU and memory actions.

There is no next-address field and no dispatch table. The instruction bits are themselves the routine number, and each instruction owns a fixed window of sixteen microinstructions. The routine numbered zero is the shared fetch sequence, and it ends by loading the next instruction. Every other routine ends by loading an all-zero word into the instruction register, and this hands control back to fetch. One side effect is intended: an instruction whose selected bits are all zero re-enters fetch for ever, and the machine halts there.

The control store is sparse. Only the routines the image defines take storage, each one tagged with its routine number. A build option drops the two lowest opcode bits, which are always ones in valid base encodings, so the address becomes 13 bits instead of 15.

Top module: `useq_core`

## Requirements
- R1: The routine number (key) is {ir[30], ir[14:12], ir[6:0]}, 11 bits. The control-store address is {key, step}, 15 bits, with the 4-bit step in the low bits.
- R2: The control word is the store entry at the current address. An address whose key matches no defined routine yields an all-zero word. No two routines share a key.
- R3: When the load strobe is high at a clock edge, the step counter becomes 0. Otherwise it increases by exactly one.
- R4: The instruction register takes the instruction word at an edge where the load strobe is high. When the strobe is low, the instruction word input has no effect on the register.
- R5: While reset is asserted, the instruction register and the step counter are zero, so the output is fetch entry 0. After release, counting starts with the fetch routine.
- R6: Loading an all-zero word at the last step of a routine puts the sequencer at address 0, the first fetch microinstruction, on the next cycle.
- R7: A loaded instruction whose key is zero, with other bits nonzero, runs the fetch routine again and never reaches any other routine.
- R8: A routine is at most 16 steps long. Step 15 is reachable, and the step counter never wraps from 15 without a load.
- R9: With the reduced build option, the key is {ir[30], ir[14:12], ir[6:2]}, 9 bits, and the address is 13 bits. Any nonzero key must then come from a word whose bits [1:0] are 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_load_i | input | 1 | Instruction-register load strobe from the datapath |
| ir_word_i | input | 32 | Word to load: the fetched instruction, or zero to end a routine |
| ctrl_word_o | output | 32 | Control word for the current microinstruction |
| ir_o | output | 32 | Instruction register contents, for field decoding in the datapath |
| ustep_o | output | 4 | Current micro-step |
| uaddr_o | output | 15 (13 reduced) | Current control-store address |

## Verification
A wrong step count or instruction register shows up at the ports in the very next cycle. The address output and the control word then name the wrong routine or the wrong row, and the bench checks both every cycle. A key that is formed badly either lands in an empty slot and gives zero, or it reaches the wrong tag and gives a word whose routine byte is wrong. A broken handoff keeps fetch words from appearing in the cycle right after the zero load. A broken halt path lets a zero-key instruction leave the fetch routine one cycle after it is loaded.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // Instruction width and the width of the opcode/function selection
  localparam int unsigned INSN_W = 32;
  localparam int unsigned OPF_W  = 11;

  typedef logic [INSN_W-1:0] insn_t;
  typedef logic [OPF_W-1:0]  opf_t;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_nq
);
  logic [1:0] sync_q;

  // Assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_nq = sync_q[1];
endmodule

// File: rtl/useq_ir_reg.sv
module useq_ir_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_nq,
  input  logic         ld_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (ld_en) q_n = d;
  end

  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) q <= '0;
    else         q <= q_n;
  end

  AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_nq)
    ($past(rst_nq) && $past(ld_en)) |-> (q == $past(d))); // R4
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_nq)
    ($past(rst_nq) && !$past(ld_en)) |-> (q == $past(q))); // R4
endmodule

// File: rtl/useq_step_ctr.sv
module useq_step_ctr #(
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_nq,
  input  logic              clr,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST = '1;

  logic [STEP_W-1:0] step_n;

  always_comb begin
    if (clr) step_n = '0;
    else     step_n = step + STEP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) step <= '0;
    else         step <= step_n;
  end

  AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_nq)
    ($past(rst_nq) && $past(clr)) |-> (step == '0)); // R3
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_nq)
    ($past(rst_nq) && !$past(clr)) |-> (step == STEP_W'($past(step) + STEP_W'(1)))); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_nq)
    (step == LAST) |-> clr); // R8
endmodule

// File: rtl/useq_addr_form.sv
module useq_addr_form
  import useq_pkg::*;
#(
  parameter int unsigned STEP_W    = 4,
  parameter int unsigned DROP_LOW2 = 0,
  parameter int unsigned KEY_W     = OPF_W - 2*DROP_LOW2
) (
  input  opf_t                     opf,
  input  logic [STEP_W-1:0]        step,
  output logic [KEY_W-1:0]         key,
  output logic [KEY_W+STEP_W-1:0]  addr
);
  generate
    if (DROP_LOW2 != 0) begin : g_reduced
      assign key = opf[OPF_W-1:2];
    end else begin : g_full
      assign key = opf;
    end
  endgenerate

  // Opcode bits sit above the step, so each routine owns 2**STEP_W rows
  assign addr = {key, step};
endmodule

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
  import useq_pkg::*;
#(
  parameter int unsigned CW     = 32,
  parameter int unsigned STEP_W = 4,
  parameter int unsigned KEY_W  = 11,
  parameter int unsigned SLOTS  = 1,
  parameter logic [SLOTS*OPF_W-1:0]             SLOT_KEYS = '0,
  parameter logic [SLOTS*(2**STEP_W)*CW-1:0]    IMAGE     = '0
) (
  input  logic              clk,
  input  logic              rst_nq,
  input  logic [KEY_W-1:0]  key,
  input  logic [STEP_W-1:0] step,
  output logic [CW-1:0]     word
);
  localparam int unsigned STEPS = 2**STEP_W;

  logic [SLOTS-1:0] hit;
  logic [CW-1:0]    pick [SLOTS];

  // One tag compare per populated routine; empty space reads as zero
  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign hit[g]  = (key == SLOT_KEYS[g*OPF_W +: KEY_W]);
      assign pick[g] = hit[g] ? IMAGE[(g*STEPS + int'(step))*CW +: CW] : '0;
    end
  endgenerate

  always_comb begin
    word = '0;
    for (int i = 0; i < SLOTS; i++) word = word | pick[i];
  end

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_nq)
    $onehot0(hit)); // R2
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int unsigned CW        = 32,
  parameter int unsigned STEP_W    = 4,
  parameter int unsigned DROP_LOW2 = 0,
  parameter int unsigned SLOTS     = 1,
  parameter logic [SLOTS*OPF_W-1:0]          SLOT_KEYS = '0,
  parameter logic [SLOTS*(2**STEP_W)*CW-1:0] IMAGE     = '0
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   ir_load_i,
  input  logic [INSN_W-1:0]                      ir_word_i,
  output logic [CW-1:0]                          ctrl_word_o,
  output logic [INSN_W-1:0]                      ir_o,
  output logic [STEP_W-1:0]                      ustep_o,
  output logic [OPF_W-2*DROP_LOW2+STEP_W-1:0]    uaddr_o
);
  localparam int unsigned KEY_W  = OPF_W - 2*DROP_LOW2;
  localparam int unsigned ADDR_W = KEY_W + STEP_W;

  logic              rst_nq;
  insn_t             ir_q;
  opf_t              opf;
  logic [STEP_W-1:0] step;
  logic [KEY_W-1:0]  key;
  logic [ADDR_W-1:0] addr;

  useq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_nq (rst_nq)
  );

  useq_ir_reg #(.W(INSN_W)) u_ir (
    .clk    (clk),
    .rst_nq (rst_nq),
    .ld_en  (ir_load_i),
    .d      (ir_word_i),
    .q      (ir_q)
  );

  useq_step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk    (clk),
    .rst_nq (rst_nq),
    .clr    (ir_load_i),
    .step   (step)
  );

  assign opf = {ir_q[30], ir_q[14:12], ir_q[6:0]};

  useq_addr_form #(
    .STEP_W    (STEP_W),
    .DROP_LOW2 (DROP_LOW2),
    .KEY_W     (KEY_W)
  ) u_addr (
    .opf  (opf),
    .step (step),
    .key  (key),
    .addr (addr)
  );

  useq_ctrl_store #(
    .CW        (CW),
    .STEP_W    (STEP_W),
    .KEY_W     (KEY_W),
    .SLOTS     (SLOTS),
    .SLOT_KEYS (SLOT_KEYS),
    .IMAGE     (IMAGE)
  ) u_store (
    .clk    (clk),
    .rst_nq (rst_nq),
    .key    (key),
    .step   (step),
    .word   (ctrl_word_o)
  );

  assign ir_o    = ir_q;
  assign ustep_o = step;
  assign uaddr_o = addr;

  AST_FETCH_RETURN: assert property (@(posedge clk) disable iff (!rst_nq)
    ($past(rst_nq) && $past(ir_load_i) && ($past(ir_word_i) == '0)) |-> (uaddr_o == '0)); // R6

  generate
    if (DROP_LOW2 != 0) begin : g_low_chk
      AST_LOW_PAIR: assert property (@(posedge clk) disable iff (!rst_nq)
        (key != '0) |-> (opf[1:0] == 2'b11)); // R9
    end
  endgenerate
endmodule

// File: tb/useq_core_test.sv
`timescale 1ns/1ps
module useq_core_test;
  localparam int unsigned NS = 4;

  function automatic logic [31:0] w_of(int g, int s);
    return {8'hC5, 8'(g), 8'h5A, 8'(s)};
  endfunction

  function automatic logic [NS*16*32-1:0] mk_img();
    logic [NS*16*32-1:0] img;
    img = '0;
    for (int g = 0; g < NS; g++)
      for (int s = 0; s < 16; s++)
        img[(g*16+s)*32 +: 32] = w_of(g, s);
    return img;
  endfunction

  localparam logic [NS*16*32-1:0] IMG = mk_img();
  localparam logic [NS*11-1:0] KEYS_F = {11'h433, 11'h033, 11'h013, 11'h000};
  localparam logic [NS*11-1:0] KEYS_R = {11'h10C, 11'h00C, 11'h004, 11'h000};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_load;
  logic [31:0] ir_word;
  logic [31:0] ctrl_f, ctrl_l, ir_f, ir_l;
  logic [3:0]  step_f, step_l;
  logic [14:0] uaddr_f;
  logic [12:0] uaddr_l;

  always #5 clk = ~clk;

  useq_core #(.SLOTS(NS), .SLOT_KEYS(KEYS_F), .IMAGE(IMG)) uut (
    .clk(clk), .rst_n(rst_n), .ir_load_i(ir_load), .ir_word_i(ir_word),
    .ctrl_word_o(ctrl_f), .ir_o(ir_f), .ustep_o(step_f), .uaddr_o(uaddr_f));

  useq_core #(.DROP_LOW2(1), .SLOTS(NS), .SLOT_KEYS(KEYS_R), .IMAGE(IMG)) uut_lite (
    .clk(clk), .rst_n(rst_n), .ir_load_i(ir_load), .ir_word_i(ir_word),
    .ctrl_word_o(ctrl_l), .ir_o(ir_l), .ustep_o(step_l), .uaddr_o(uaddr_l));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] cur;

  function automatic logic [10:0] fk(logic [31:0] i);
    return {i[30], i[14:12], i[6:0]};
  endfunction
  function automatic logic [8:0] rk(logic [31:0] i);
    return {i[30], i[14:12], i[6:2]};
  endfunction
  function automatic logic [31:0] exp_word(logic [31:0] i, int s);
    case (fk(i))
      11'h000: return w_of(0, s);
      11'h013: return w_of(1, s);
      11'h033: return w_of(2, s);
      11'h433: return w_of(3, s);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Full and reduced builds: word, address and step at micro-step s
  task automatic observe(string req, logic [31:0] i, int s);
    chk({req, " word"}, ctrl_f, exp_word(i, s));
    chk("R1 address", {17'b0, uaddr_f}, {17'b0, fk(i), 4'(s)});
    chk("R3 step", {28'b0, step_f}, 32'(s));
    chk({req, " reduced word"}, ctrl_l, exp_word(i, s));
    chk("R9 reduced address", {19'b0, uaddr_l}, {19'b0, rk(i), 4'(s)});
  endtask

  // Datapath stand-in: six-step fetch that loads 'nxt' on its last step
  task automatic run_fetch(string req, logic [31:0] nxt);
    for (int s = 0; s < 6; s++) begin
      observe(req, cur, s);
      if (s == 5) begin
        ir_load = 1'b1;
        ir_word = nxt;
      end
      tick();
      ir_load = 1'b0;
      ir_word = 32'h0;
    end
    cur = nxt;
    chk("R4 load", ir_f, nxt);
  endtask

  // Routine of 'len' steps; ends by loading zero. Junk on ir_word while idle.
  task automatic run_routine(string req, int len);
    for (int s = 0; s < len; s++) begin
      observe(req, cur, s);
      chk("R4 hold", ir_f, cur);
      if (s == len - 1) begin
        ir_load = 1'b1;
        ir_word = 32'h0;
      end else begin
        ir_word = 32'hDEAD0033 ^ 32'(s << 20);
      end
      tick();
      ir_load = 1'b0;
      ir_word = 32'h0;
    end
    cur = 32'h0;
    chk("R6 back to fetch", {17'b0, uaddr_f}, 32'h0);
  endtask

  initial begin
    logic [31:0] sweep [3];
    sweep[0] = 32'h00A08093;
    sweep[1] = 32'h002081B3;
    sweep[2] = 32'h40208233;
    rst_n   = 1'b0;
    ir_load = 1'b0;
    ir_word = 32'h0;
    cur     = 32'h0;
    tick(); tick(); tick();
    observe("R5 in reset", 32'h0, 0);
    chk("R5 ir", ir_f, 32'h0);
    ir_load = 1'b1;
    ir_word = 32'h00A08093;
    tick();
    ir_load = 1'b0;
    chk("R5 load held in reset", ir_f, 32'h0);
    rst_n = 1'b1;
    tick(); tick();
    observe("R5 after release", 32'h0, 0);

    run_fetch("R5 first fetch", 32'h00A08093);
    run_routine("R2 addi", 3);
    run_fetch("R6 fetch", 32'h002081B3);
    run_routine("R2 add", 4);
    run_fetch("R6 fetch", 32'h40208233);
    run_routine("R1 sub", 5);

    run_fetch("R6 fetch", 32'h0000006F);
    run_routine("R2 empty slot", 4);

    run_fetch("R6 fetch", 32'hABC00000);
    run_fetch("R7 halt", 32'hABC00000);
    run_fetch("R7 halt", 32'hABC00000);
    chk("R7 ir kept", ir_f, 32'hABC00000);
    run_fetch("R7 halt", 32'h00A08093);
    run_routine("R2 after halt", 2);

    for (int k = 0; k < 3; k++) begin
      run_fetch("R6 fetch", sweep[k]);
      run_routine("R8 full window", 16);
    end
    observe("R6 final", 32'h0, 0);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule